// File: doc/BRIEF.md
# Wrapping Stack Pointer and Context Sequencer

This block owns the stack pointer of a small 8-bit processor and moves bytes between the processor's working registers and a 256-byte stack page in memory. The page number is a fixed parameter, so only the low byte of the pointer ever changes. It runs in both directions without limit and raises no flag when it passes either end; whatever was stored there earlier is simply overwritten. The pointer always names the next free byte. A store writes at the pointer and then steps it down. A fetch first steps it up and then reads at the new address.

The sequencer handles eight commands. Single-byte push and pop are the basic pair. A call saves a 16-bit return address and a return fetches it back. An interrupt entry saves five context bytes and an interrupt return restores them. The remaining two set the pointer directly: one resets it to the top of the page, the other loads its low byte. Multi-byte commands spend one clock per byte on a byte-wide memory port. A busy output stays high until the sequence completes, and every command seen while busy is dropped.

Restored values leave on result ports, each qualified by a one-cycle valid strobe. The strobes have no ready input, so the consumer must take a result in the cycle it is offered. Command inputs are plain level signals sampled on each rising edge while idle.

Top module: `stack_engine`

## Requirements
- R1: After reset the pointer output reads 0x01FF, busy is low and neither memory enable is asserted.
- R2: A push writes push_data at the address the pointer holds, then lowers the low byte by one. Busy is high for exactly one cycle.
- R3: A pop raises the low byte by one and then issues a read at the new address. Read data is taken on the second rising edge after the read enable. pop_valid pulses with that byte in the cycle after busy has been high for two cycles.
- R4: The low byte wraps from 0x00 to 0xFF when lowered and from 0xFF to 0x00 when raised. The upper byte of the pointer and of every memory address stays at 0x01, and no error indication exists.
- R5: The reset-pointer command sets the low byte to 0xFF on the next edge without touching memory or raising busy.
- R6: The load command copies load_val into the low byte on the next edge, and the new value is visible on the pointer output.
- R7: A call stores pc_in bits 7:0 at the pointer and pc_in bits 15:8 one address lower. The pointer drops by two and busy lasts two cycles.
- R8: A return reads the high byte at pointer+1 and the low byte at pointer+2. It presents them as ret_pc = {high, low} with ret_valid, leaves the pointer two higher, and keeps busy high for three cycles.
- R9: An interrupt entry stores five bytes at the pointer and the four addresses below it, in the order PC low, PC high, X, A, CC. The pointer drops by five and busy lasts five cycles.
- R10: An interrupt return reads from pointer+1 to pointer+5, which hold CC, A, X, PC high and PC low in that order. It presents all of them with iret_valid, leaves the pointer five higher, and keeps busy high for six cycles.
- R11: Any command seen while busy is high, including reset-pointer and load, has no effect on the pointer, the memory or the results.
- R12: When several commands are high together while idle, only one runs, chosen in the order reset-pointer, interrupt, call, return, interrupt return, push, pop, load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_rsp | input | 1 | Reset the pointer to the top of the page |
| cmd_int | input | 1 | Interrupt entry: save the five-byte context |
| cmd_call | input | 1 | Call: save the return address |
| cmd_ret | input | 1 | Return: restore the return address |
| cmd_iret | input | 1 | Interrupt return: restore the five-byte context |
| cmd_push | input | 1 | Push one byte |
| cmd_pop | input | 1 | Pop one byte |
| cmd_load | input | 1 | Load the low pointer byte |
| load_val | input | 8 | Value for the load command |
| push_data | input | 8 | Byte stored by a push |
| pc_in | input | 16 | Program counter saved by a call or an interrupt entry |
| x_in | input | 8 | X register saved by an interrupt entry |
| a_in | input | 8 | Accumulator saved by an interrupt entry |
| cc_in | input | 8 | Condition codes saved by an interrupt entry |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | A multi-cycle sequence is in progress |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_re |
| pop_valid | output | 1 | pop_data is valid this cycle |
| pop_data | output | 8 | Byte returned by a pop |
| ret_valid | output | 1 | ret_pc is valid this cycle |
| ret_pc | output | 16 | Address returned by a return |
| iret_valid | output | 1 | Interrupt-return results are valid this cycle |
| iret_pc | output | 16 | Restored program counter |
| iret_x | output | 8 | Restored X |
| iret_a | output | 8 | Restored accumulator |
| iret_cc | output | 8 | Restored condition codes |

## Verification
The bench builds the block with its defaults: an 8-bit data path, an 8-bit pointer field and page 0x01. A 256-entry page is therefore small enough to sweep completely. Every low-byte value is loaded and reset, and call/return and interrupt/return pairs are started from each of the 256 pointer positions. Runs of 300 pushes and pops cross both wrap boundaries. Priority combinations are checked, and commands are held asserted during a busy interrupt sequence. Expected pointers, memory images and restored values come from a byte-array model in the bench.

// File: rtl/stack_pkg.sv
package stack_pkg;
  // sequencer phase
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_DRAIN
  } seq_state_t;

  // which restore sequence produced the gathered bytes
  typedef enum logic [1:0] {
    RK_POP,
    RK_RET,
    RK_IRET
  } rd_kind_t;

  // context frame: two program-counter bytes plus three register bytes
  localparam int PC_BYTES  = 2;
  localparam int REG_BYTES = 3;
  localparam int CTX_BYTES = PC_BYTES + REG_BYTES;
endpackage

// File: rtl/stack_ptr.sv
module stack_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_dec,
  input  logic             do_inc,
  input  logic             do_rsp,
  input  logic             do_load,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] ptr
);

  // low pointer field; modulo arithmetic gives the silent wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '1;
    else if (do_rsp)  ptr <= '1;
    else if (do_load) ptr <= load_val;
    else if (do_dec)  ptr <= ptr - 1'b1;
    else if (do_inc)  ptr <= ptr + 1'b1;
  end

  assert_one_update_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_dec, do_inc, do_rsp, do_load}));

  assert_rsp_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_rsp |=> (ptr == '1));

  assert_dec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_dec && !do_rsp && !do_load) |=> (ptr == PTR_W'($past(ptr) - 1'b1)));

  assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_inc && !do_rsp && !do_load && !do_dec) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_rsp,
  input  logic                  cmd_int,
  input  logic                  cmd_call,
  input  logic                  cmd_ret,
  input  logic                  cmd_iret,
  input  logic                  cmd_push,
  input  logic                  cmd_pop,
  input  logic                  cmd_load,
  input  logic [DATA_W-1:0]     push_data,
  input  logic [2*DATA_W-1:0]   pc_in,
  input  logic [DATA_W-1:0]     x_in,
  input  logic [DATA_W-1:0]     a_in,
  input  logic [DATA_W-1:0]     cc_in,
  input  logic [PTR_W-1:0]      ptr,
  output logic                  do_dec,
  output logic                  do_inc,
  output logic                  do_rsp,
  output logic                  do_load,
  output logic                  mem_we,
  output logic                  mem_re,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic                  busy,
  output logic                  cap_en,
  output logic                  fin,
  output rd_kind_t              kind
);

  localparam int BUF_W = CTX_BYTES * DATA_W;
  localparam int CNT_W = $clog2(CTX_BYTES + 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [BUF_W-1:0] wbuf;
  logic             idle;
  logic sel_rsp, sel_int, sel_call, sel_ret, sel_iret, sel_push, sel_pop, sel_load;

  assign idle = (state == ST_IDLE);

  // fixed priority, evaluated only while idle; all else is dropped
  always_comb begin
    sel_rsp  = 1'b0;
    sel_int  = 1'b0;
    sel_call = 1'b0;
    sel_ret  = 1'b0;
    sel_iret = 1'b0;
    sel_push = 1'b0;
    sel_pop  = 1'b0;
    sel_load = 1'b0;
    if (idle) begin
      if (cmd_rsp)       sel_rsp  = 1'b1;
      else if (cmd_int)  sel_int  = 1'b1;
      else if (cmd_call) sel_call = 1'b1;
      else if (cmd_ret)  sel_ret  = 1'b1;
      else if (cmd_iret) sel_iret = 1'b1;
      else if (cmd_push) sel_push = 1'b1;
      else if (cmd_pop)  sel_pop  = 1'b1;
      else if (cmd_load) sel_load = 1'b1;
    end
  end

  assign do_rsp    = sel_rsp;
  assign do_load   = sel_load;
  assign do_dec    = (state == ST_WR);
  assign do_inc    = sel_ret || sel_iret || sel_pop ||
                     ((state == ST_RD) && (cnt > CNT_W'(1)));
  assign mem_we    = (state == ST_WR);
  assign mem_re    = (state == ST_RD);
  assign mem_wdata = wbuf[DATA_W-1:0];
  assign busy      = !idle;
  assign fin       = (state == ST_DRAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      wbuf   <= '0;
      kind   <= RK_POP;
      cap_en <= 1'b0;
    end else begin
      cap_en <= (state == ST_RD);
      unique case (state)
        ST_IDLE: begin
          if (sel_int) begin
            wbuf  <= {cc_in, a_in, x_in, pc_in};
            cnt   <= CNT_W'(CTX_BYTES);
            state <= ST_WR;
          end else if (sel_call) begin
            wbuf  <= BUF_W'(pc_in);
            cnt   <= CNT_W'(PC_BYTES);
            state <= ST_WR;
          end else if (sel_ret) begin
            kind  <= RK_RET;
            cnt   <= CNT_W'(PC_BYTES);
            state <= ST_RD;
          end else if (sel_iret) begin
            kind  <= RK_IRET;
            cnt   <= CNT_W'(CTX_BYTES);
            state <= ST_RD;
          end else if (sel_push) begin
            wbuf  <= BUF_W'(push_data);
            cnt   <= CNT_W'(1);
            state <= ST_WR;
          end else if (sel_pop) begin
            kind  <= RK_POP;
            cnt   <= CNT_W'(1);
            state <= ST_RD;
          end
        end
        ST_WR: begin
          wbuf <= wbuf >> DATA_W;
          cnt  <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) state <= ST_IDLE;
        end
        ST_RD: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) state <= ST_DRAIN;
        end
        ST_DRAIN: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_pop_inc_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sel_pop) |=> (mem_re && ptr == PTR_W'($past(ptr) + 1'b1)));

  assert_int_pcl_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sel_int) |=> (mem_we && mem_wdata == $past(pc_in[DATA_W-1:0])));

  assert_call_pcl_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sel_call) |=> (mem_we && mem_wdata == $past(pc_in[DATA_W-1:0])));

  assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(do_rsp || do_load));

  assert_no_rw_clash_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

endmodule

// File: rtl/stack_gather.sv
module stack_gather
  import stack_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic                fin,
  input  rd_kind_t            kind,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                pop_valid,
  output logic [DATA_W-1:0]   pop_data,
  output logic                ret_valid,
  output logic [2*DATA_W-1:0] ret_pc,
  output logic                iret_valid,
  output logic [2*DATA_W-1:0] iret_pc,
  output logic [DATA_W-1:0]   iret_x,
  output logic [DATA_W-1:0]   iret_a,
  output logic [DATA_W-1:0]   iret_cc
);

  localparam int BUF_W = CTX_BYTES * DATA_W;
  localparam int PC_W  = 2 * DATA_W;

  logic [BUF_W-1:0] shreg;
  logic [BUF_W-1:0] nxt;

  // first byte read ends up highest, last byte lowest
  assign nxt = {shreg[BUF_W-DATA_W-1:0], mem_rdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      pop_valid  <= 1'b0;
      ret_valid  <= 1'b0;
      iret_valid <= 1'b0;
      pop_data   <= '0;
      ret_pc     <= '0;
      iret_pc    <= '0;
      iret_x     <= '0;
      iret_a     <= '0;
      iret_cc    <= '0;
    end else begin
      pop_valid  <= 1'b0;
      ret_valid  <= 1'b0;
      iret_valid <= 1'b0;
      if (cap_en) shreg <= nxt;
      if (fin) begin
        unique case (kind)
          RK_POP: begin
            pop_valid <= 1'b1;
            pop_data  <= nxt[DATA_W-1:0];
          end
          RK_RET: begin
            ret_valid <= 1'b1;
            ret_pc    <= nxt[PC_W-1:0];
          end
          RK_IRET: begin
            iret_valid <= 1'b1;
            iret_pc    <= nxt[PC_W-1:0];
            iret_x     <= nxt[PC_W +: DATA_W];
            iret_a     <= nxt[PC_W+DATA_W +: DATA_W];
            iret_cc    <= nxt[PC_W+2*DATA_W +: DATA_W];
          end
          default: ;
        endcase
      end
    end
  end

  assert_last_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> cap_en);

  assert_single_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_valid, ret_valid, iret_valid}));

  assert_pulse_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !ret_valid);

endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stack_pkg::*;
#(
  parameter int                       DATA_W = 8,
  parameter int                       PTR_W  = 8,
  parameter int                       ADDR_W = 16,
  parameter logic [ADDR_W-PTR_W-1:0]  PAGE   = 'h01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_rsp,
  input  logic                cmd_int,
  input  logic                cmd_call,
  input  logic                cmd_ret,
  input  logic                cmd_iret,
  input  logic                cmd_push,
  input  logic                cmd_pop,
  input  logic                cmd_load,
  input  logic [PTR_W-1:0]    load_val,
  input  logic [DATA_W-1:0]   push_data,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0]   x_in,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   cc_in,
  output logic [ADDR_W-1:0]   sp,
  output logic                busy,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                pop_valid,
  output logic [DATA_W-1:0]   pop_data,
  output logic                ret_valid,
  output logic [2*DATA_W-1:0] ret_pc,
  output logic                iret_valid,
  output logic [2*DATA_W-1:0] iret_pc,
  output logic [DATA_W-1:0]   iret_x,
  output logic [DATA_W-1:0]   iret_a,
  output logic [DATA_W-1:0]   iret_cc
);

  logic [PTR_W-1:0] ptr;
  logic do_dec, do_inc, do_rsp, do_load;
  logic cap_en, fin;
  rd_kind_t kind;

  stack_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .do_dec   (do_dec),
    .do_inc   (do_inc),
    .do_rsp   (do_rsp),
    .do_load  (do_load),
    .load_val (load_val),
    .ptr      (ptr)
  );

  stack_seq #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_rsp   (cmd_rsp),
    .cmd_int   (cmd_int),
    .cmd_call  (cmd_call),
    .cmd_ret   (cmd_ret),
    .cmd_iret  (cmd_iret),
    .cmd_push  (cmd_push),
    .cmd_pop   (cmd_pop),
    .cmd_load  (cmd_load),
    .push_data (push_data),
    .pc_in     (pc_in),
    .x_in      (x_in),
    .a_in      (a_in),
    .cc_in     (cc_in),
    .ptr       (ptr),
    .do_dec    (do_dec),
    .do_inc    (do_inc),
    .do_rsp    (do_rsp),
    .do_load   (do_load),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .cap_en    (cap_en),
    .fin       (fin),
    .kind      (kind)
  );

  stack_gather #(.DATA_W(DATA_W)) u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .fin        (fin),
    .kind       (kind),
    .mem_rdata  (mem_rdata),
    .pop_valid  (pop_valid),
    .pop_data   (pop_data),
    .ret_valid  (ret_valid),
    .ret_pc     (ret_pc),
    .iret_valid (iret_valid),
    .iret_pc    (iret_pc),
    .iret_x     (iret_x),
    .iret_a     (iret_a),
    .iret_cc    (iret_cc)
  );

  // the page field is fixed; only the low field moves
  assign sp       = {PAGE, ptr};
  assign mem_addr = {PAGE, ptr};

  assert_result_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pop_valid) |-> $past(busy));

  assert_write_moves_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp != $past(sp)));

endmodule

// File: tb/stack_engine_test.sv
`timescale 1ns/1ps
module stack_engine_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cmd_rsp, cmd_int, cmd_call, cmd_ret, cmd_iret, cmd_push, cmd_pop, cmd_load;
  logic [7:0]  load_val, push_data, x_in, a_in, cc_in;
  logic [15:0] pc_in;
  logic [15:0] sp, mem_addr;
  logic        busy, mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        pop_valid, ret_valid, iret_valid;
  logic [7:0]  pop_data, iret_x, iret_a, iret_cc;
  logic [15:0] ret_pc, iret_pc;

  stack_engine uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_rsp(cmd_rsp), .cmd_int(cmd_int), .cmd_call(cmd_call), .cmd_ret(cmd_ret),
    .cmd_iret(cmd_iret), .cmd_push(cmd_push), .cmd_pop(cmd_pop), .cmd_load(cmd_load),
    .load_val(load_val), .push_data(push_data), .pc_in(pc_in),
    .x_in(x_in), .a_in(a_in), .cc_in(cc_in),
    .sp(sp), .busy(busy), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .pop_valid(pop_valid), .pop_data(pop_data), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .iret_valid(iret_valid), .iret_pc(iret_pc), .iret_x(iret_x), .iret_a(iret_a),
    .iret_cc(iret_cc)
  );

  // RAM model: read data registered one edge after the read enable
  logic [7:0] ram [256];
  int page_bad = 0;
  always @(posedge clk) begin
    if (mem_we || mem_re) begin
      if (mem_addr[15:8] != 8'h01) page_bad++;
    end
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
  end

  // command bit positions in the drive mask
  localparam int B_RSP = 0, B_INT = 1, B_CALL = 2, B_RET = 3,
                 B_IRET = 4, B_PUSH = 5, B_POP = 6, B_LOAD = 7;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_mem [256];
  logic [7:0] m_sp;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic m_wr(input logic [7:0] d);
    m_mem[m_sp] = d;
    m_sp = m_sp - 8'd1;
  endtask

  function automatic logic [7:0] m_rd();
    m_sp = m_sp + 8'd1;
    return m_mem[m_sp];
  endfunction

  function automatic string tag_of(input int w);
    case (w)
      B_RSP:  return "R5";
      B_INT:  return "R9";
      B_CALL: return "R7";
      B_RET:  return "R8";
      B_IRET: return "R10";
      B_PUSH: return "R2";
      B_POP:  return "R3";
      default: return "R6";
    endcase
  endfunction

  // drive mask for one clock, wait for idle, compare with the model run of op 'win'
  task automatic do_op(input logic [7:0] mask, input int win, input string extra);
    int cyc;
    int exp_cyc;
    int bad;
    logic [7:0] e8;
    logic [15:0] e16;
    logic [7:0] ex, ea, ec;
    string t;
    t = {tag_of(win), extra};
    @(negedge clk);
    {cmd_load, cmd_pop, cmd_push, cmd_iret, cmd_ret, cmd_call, cmd_int, cmd_rsp} = mask;
    @(negedge clk);
    {cmd_load, cmd_pop, cmd_push, cmd_iret, cmd_ret, cmd_call, cmd_int, cmd_rsp} = '0;
    cyc = 0;
    while (busy && cyc < 40) begin
      cyc++;
      @(negedge clk);
    end
    e8 = '0; e16 = '0; ex = '0; ea = '0; ec = '0;
    case (win)
      B_RSP:  begin m_sp = 8'hFF; exp_cyc = 0; end
      B_LOAD: begin m_sp = load_val; exp_cyc = 0; end
      B_PUSH: begin m_wr(push_data); exp_cyc = 1; end
      B_POP:  begin e8 = m_rd(); exp_cyc = 2; end
      B_CALL: begin m_wr(pc_in[7:0]); m_wr(pc_in[15:8]); exp_cyc = 2; end
      B_RET:  begin e16[15:8] = m_rd(); e16[7:0] = m_rd(); exp_cyc = 3; end
      B_INT:  begin
        m_wr(pc_in[7:0]); m_wr(pc_in[15:8]); m_wr(x_in); m_wr(a_in); m_wr(cc_in);
        exp_cyc = 5;
      end
      default: begin
        ec = m_rd(); ea = m_rd(); ex = m_rd(); e16[15:8] = m_rd(); e16[7:0] = m_rd();
        exp_cyc = 6;
      end
    endcase
    chk(t, "busy cycles", 64'(cyc), 64'(exp_cyc));
    chk(t, "pointer", 64'(sp), 64'({8'h01, m_sp}));
    if (win == B_POP) begin
      chk(t, "pop_valid", 64'(pop_valid), 64'd1);
      chk(t, "pop_data", 64'(pop_data), 64'(e8));
    end
    if (win == B_RET) begin
      chk(t, "ret_valid", 64'(ret_valid), 64'd1);
      chk(t, "ret_pc", 64'(ret_pc), 64'(e16));
    end
    if (win == B_IRET) begin
      chk(t, "iret_valid", 64'(iret_valid), 64'd1);
      chk(t, "iret regs", {16'h0, iret_pc, iret_x, iret_a, iret_cc},
          {16'h0, e16, ex, ea, ec});
    end
    bad = 0;
    for (int i = 0; i < 256; i++) if (ram[i] !== m_mem[i]) bad++;
    chk(t, "memory image mismatches", 64'(bad), 64'd0);
  endtask

  initial begin
    {cmd_load, cmd_pop, cmd_push, cmd_iret, cmd_ret, cmd_call, cmd_int, cmd_rsp} = '0;
    load_val = '0; push_data = '0; pc_in = '0; x_in = '0; a_in = '0; cc_in = '0;
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'h00;
      m_mem[i] = 8'h00;
    end
    m_sp = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "pointer", 64'(sp), 64'h01FF);
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "mem enables", 64'({mem_we, mem_re}), 64'd0);

    // R2 / R4: 300 pushes run across the lower end of the page
    for (int i = 0; i < 300; i++) begin
      push_data = 8'((i * 7 + 3) & 255);
      do_op(8'(1 << B_PUSH), B_PUSH, " R4 wrap down");
    end
    // R3 / R4: 300 pops run back across the upper end
    for (int i = 0; i < 300; i++) do_op(8'(1 << B_POP), B_POP, " R4 wrap up");

    // R6 and R5: every low-byte value loaded, then reset to the top
    for (int v = 0; v < 256; v++) begin
      load_val = 8'(v);
      do_op(8'(1 << B_LOAD), B_LOAD, "");
      do_op(8'(1 << B_RSP), B_RSP, "");
    end

    // R7/R8 and R9/R10 from every starting pointer
    for (int s = 0; s < 256; s++) begin
      load_val = 8'(s);
      do_op(8'(1 << B_LOAD), B_LOAD, "");
      pc_in = {8'(s), 8'(~s)};
      do_op(8'(1 << B_CALL), B_CALL, "");
      do_op(8'(1 << B_RET), B_RET, "");
      pc_in = {8'(s ^ 8'h5A), 8'(s + 1)};
      x_in = 8'(s * 3); a_in = 8'(s + 77); cc_in = 8'(s ^ 8'hC3);
      do_op(8'(1 << B_INT), B_INT, "");
      do_op(8'(1 << B_IRET), B_IRET, "");
    end

    // R11: commands held during a busy interrupt entry are dropped
    load_val = 8'h40;
    do_op(8'(1 << B_LOAD), B_LOAD, " R11 setup");
    begin
      int cyc;
      @(negedge clk);
      pc_in = 16'h1234; x_in = 8'h11; a_in = 8'h22; cc_in = 8'h33;
      cmd_int = 1'b1;
      @(negedge clk);
      cmd_int = 1'b0;
      push_data = 8'hEE; load_val = 8'h05;
      {cmd_rsp, cmd_push, cmd_pop, cmd_load, cmd_call} = '1;
      repeat (4) @(negedge clk);
      {cmd_rsp, cmd_push, cmd_pop, cmd_load, cmd_call} = '0;
      cyc = 0;
      while (busy && cyc < 40) begin
        cyc++;
        @(negedge clk);
      end
      m_wr(8'h34); m_wr(8'h12); m_wr(8'h11); m_wr(8'h22); m_wr(8'h33);
      chk("R11", "pointer after busy", 64'(sp), 64'({8'h01, m_sp}));
      chk("R11", "byte below frame untouched", 64'(ram[8'h3B]), 64'(m_mem[8'h3B]));
      chk("R11", "no pop result", 64'(pop_valid), 64'd0);
      repeat (2) @(negedge clk);
      chk("R11", "still idle", 64'({busy, mem_we, mem_re}), 64'd0);
    end

    // R12 priority combinations
    load_val = 8'h80;
    do_op(8'(1 << B_LOAD), B_LOAD, " R12 setup");
    pc_in = 16'hA1B2; x_in = 8'h01; a_in = 8'h02; cc_in = 8'h03; push_data = 8'h99;
    do_op(8'((1 << B_INT) | (1 << B_CALL) | (1 << B_PUSH) | (1 << B_POP)), B_INT, " R12");
    pc_in = 16'hC3D4;
    do_op(8'((1 << B_CALL) | (1 << B_RET) | (1 << B_PUSH) | (1 << B_LOAD)), B_CALL, " R12");
    do_op(8'((1 << B_RET) | (1 << B_IRET) | (1 << B_PUSH) | (1 << B_POP)), B_RET, " R12");
    do_op(8'((1 << B_IRET) | (1 << B_PUSH) | (1 << B_POP)), B_IRET, " R12");
    do_op(8'((1 << B_PUSH) | (1 << B_POP) | (1 << B_LOAD)), B_PUSH, " R12");
    do_op(8'((1 << B_POP) | (1 << B_LOAD)), B_POP, " R12");
    do_op(8'((1 << B_RSP) | (1 << B_INT) | (1 << B_LOAD)), B_RSP, " R12");

    // R4: every access stayed on page 0x01
    chk("R4", "accesses off page", 64'(page_bad), 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule